// File: doc/BRIEF.md
# Extended-Precision Value Classifier

This block sorts one 80-bit extended-precision register value into a class and reports it as a four-bit condition code. The code has the shape that a floating-point examine operation writes. The value arrives with a tag that marks the register as empty, and with a valid strobe. The block splits the value into four fields: the sign, a 15-bit biased exponent, an explicit integer bit and a 63-bit fraction. From these fields it picks one of seven classes: empty, zero, NaN, unsupported encoding, infinity, denormal or normal.

The result is registered. It appears on the clock edge that samples the strobe, and a one-cycle done pulse marks it. Between strobes the code holds its last value. Condition bit C1 always carries the sign bit, even when the register is empty. An unsupported encoding gets its own code, separate from NaN. The unsupported encodings are the pseudo-NaN, the pseudo-infinity and the unnormal.

Top module: `xcls_top`

## Requirements
- R1: While reset is held and after reset is released, `outCc` is 4'b0000 and `outDone` is 0 until the first valid strobe is sampled.
- R2: `outDone` is 1 in the cycle after each cycle in which `inValid` was 1, and 0 in the cycle after each cycle in which it was 0. Back-to-back strobes keep `outDone` high.
- R3: With `inEmpty`=1 the code is C3=1, C2=0, C0=1 (`outCc` bit 3 = C3, bit 2 = C2, bit 1 = C1, bit 0 = C0), whatever the value decodes to.
- R4: An exponent of zero (bits 78:64) with a zero significand (bits 63:0) gives C3=1, C2=0, C0=0.
- R5: An all-ones exponent with integer bit 63 set and a nonzero fraction (bits 62:0) is a NaN, signalling or quiet: C3=0, C2=0, C0=1.
- R6: A nonzero exponent with integer bit 63 clear is unsupported (pseudo-NaN, pseudo-infinity, unnormal): C3=0, C2=0, C0=0.
- R7: An all-ones exponent with integer bit 63 set and a zero fraction is an infinity: C3=0, C2=1, C0=1.
- R8: An exponent of zero with a nonzero significand is a denormal, including when integer bit 63 is set: C3=1, C2=1, C0=0.
- R9: Any other value, that is an exponent neither zero nor all ones with integer bit 63 set, is normal: C3=0, C2=1, C0=0.
- R10: C1 of every result equals bit 79 (the sign) of the sampled value, for empty and full registers alike.
- R11: When `inValid` is 0, `outCc` keeps its previous value, whatever `inValue` and `inEmpty` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: sample `inValue` and `inEmpty` this cycle |
| inValue | input | 80 | Register value: sign 79, exponent 78:64, integer bit 63, fraction 62:0 |
| inEmpty | input | 1 | The register is tagged empty |
| outCc | output | 4 | Condition code {C3, C2, C1, C0} |
| outDone | output | 1 | One-cycle pulse: `outCc` holds a fresh result |

## Verification
Two functions can act in the same cycle. The empty override and the field decode both apply when a strobe carries the empty tag together with a value that would decode as normal or as NaN. The bench sends those pairs and checks two things: the empty code wins, and C1 still follows the sign of the value. The bench also sends strobes back to back, so that the done pulse of one result lands in the same cycle as the capture of the next. It judges that case by two checks: `outDone` stays high across both strobes, and each code appears one cycle after its own strobe.

// File: rtl/xcls_pkg.sv
package xcls_pkg;

  typedef enum logic [2:0] {
    CLS_EMPTY  = 3'd0,
    CLS_ZERO   = 3'd1,
    CLS_NAN    = 3'd2,
    CLS_UNSUP  = 3'd3,
    CLS_INF    = 3'd4,
    CLS_DENORM = 3'd5,
    CLS_NORMAL = 3'd6
  } valClass_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // load a new result this cycle
    logic markEmpty;  // override decode with the empty class
  } ctrlStrobe_t;

  // Condition code {C3, C2, C1, C0} for a class and a sign
  function automatic logic [3:0] codeOf(valClass_t cls, logic sgn);
    logic c3, c2, c0;
    case (cls)
      CLS_EMPTY:  begin c3 = 1'b1; c2 = 1'b0; c0 = 1'b1; end
      CLS_ZERO:   begin c3 = 1'b1; c2 = 1'b0; c0 = 1'b0; end
      CLS_NAN:    begin c3 = 1'b0; c2 = 1'b0; c0 = 1'b1; end
      CLS_INF:    begin c3 = 1'b0; c2 = 1'b1; c0 = 1'b1; end
      CLS_DENORM: begin c3 = 1'b1; c2 = 1'b1; c0 = 1'b0; end
      CLS_NORMAL: begin c3 = 1'b0; c2 = 1'b1; c0 = 1'b0; end
      default:    begin c3 = 1'b0; c2 = 1'b0; c0 = 1'b0; end
    endcase
    return {c3, c2, sgn, c0};
  endfunction

endpackage

// File: rtl/xcls_ctrl.sv
module xcls_ctrl
  import xcls_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inEmpty,
  output ctrlStrobe_t strobe,
  output logic        outDone
);

  logic doneQ;

  always_comb begin
    strobe.capture   = inValid;
    strobe.markEmpty = inValid & inEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= inValid;
  end

  assign outDone = doneQ;

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outDone); // R2
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outDone); // R2

endmodule

// File: rtl/xcls_dpath.sv
module xcls_dpath
  import xcls_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [EXP_W+MAN_W:0]          inValue,
  output logic [3:0]                    outCc
);

  localparam int VAL_W  = 1 + EXP_W + MAN_W;
  localparam int FRAC_W = MAN_W - 1;

  logic              sgn;
  logic [EXP_W-1:0]  expo;
  logic              intBit;
  logic [FRAC_W-1:0] frac;
  logic              expZero, expOnes, fracZero;
  valClass_t         decCls;
  valClass_t         selCls;
  logic [3:0]        ccQ;

  assign sgn    = inValue[VAL_W-1];
  assign expo   = inValue[VAL_W-2 -: EXP_W];
  assign intBit = inValue[MAN_W-1];
  assign frac   = inValue[FRAC_W-1:0];

  assign expZero  = (expo == '0);
  assign expOnes  = &expo;
  assign fracZero = (frac == '0);

  always_comb begin
    if (expZero) begin
      decCls = (!intBit && fracZero) ? CLS_ZERO : CLS_DENORM;
    end else if (!intBit) begin
      decCls = CLS_UNSUP;
    end else if (expOnes) begin
      decCls = fracZero ? CLS_INF : CLS_NAN;
    end else begin
      decCls = CLS_NORMAL;
    end
  end

  assign selCls = strobe.markEmpty ? CLS_EMPTY : decCls;

  always_ff @(posedge clk) begin
    if (!rstN)              ccQ <= 4'b0000;
    else if (strobe.capture) ccQ <= codeOf(selCls, sgn);
  end

  assign outCc = ccQ;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(outCc)); // R11
  AST_SIGN_C1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (outCc[1] == $past(inValue[VAL_W-1]))); // R10
  AST_EMPTY_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.markEmpty |=> (outCc[3] && !outCc[2] && outCc[0])); // R3
  AST_UNSUP_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.markEmpty && (inValue[VAL_W-2 -: EXP_W] != '0)
     && !inValue[MAN_W-1]) |=> (!outCc[3] && !outCc[2] && !outCc[0])); // R6
  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.markEmpty && (inValue[VAL_W-2:0] == '0))
    |=> (outCc[3] && !outCc[2] && !outCc[0])); // R4

endmodule

// File: rtl/xcls_top.sv
module xcls_top
  import xcls_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [EXP_W+MAN_W:0] inValue,
  input  logic                 inEmpty,
  output logic [3:0]           outCc,
  output logic                 outDone
);

  ctrlStrobe_t strobe;

  xcls_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inEmpty (inEmpty),
    .strobe  (strobe),
    .outDone (outDone)
  );

  xcls_dpath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inValue (inValue),
    .outCc   (outCc)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (outCc == 4'b0000 && !outDone)); // R1

endmodule

// File: tb/xcls_top_tb.sv
`timescale 1ns/1ps
module xcls_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [79:0] inValue = '0;
  logic        inEmpty = 1'b0;
  logic [3:0]  outCc;
  logic        outDone;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xcls_top u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inValue(inValue),
    .inEmpty(inEmpty), .outCc(outCc), .outDone(outDone)
  );

  // {empty, value, expected {C3,C2,C1,C0}}
  localparam int NV = 16;
  localparam logic [84:0] VEC [NV] = '{
    {1'b0, 80'h0000_0000000000000000, 4'b1000},
    {1'b0, 80'h8000_0000000000000000, 4'b1010},
    {1'b0, 80'h3FFF_8000000000000000, 4'b0100},
    {1'b0, 80'hC000_C000000000000000, 4'b0110},
    {1'b0, 80'h7FFF_8000000000000000, 4'b0101},
    {1'b0, 80'hFFFF_8000000000000000, 4'b0111},
    {1'b0, 80'h7FFF_C000000000000000, 4'b0001},
    {1'b0, 80'hFFFF_8000000000000001, 4'b0011},
    {1'b0, 80'h7FFF_0000000000000000, 4'b0000},
    {1'b0, 80'h7FFF_4000000000000000, 4'b0000},
    {1'b0, 80'h8001_1234000000000000, 4'b0010},
    {1'b0, 80'h0000_0000000000000001, 4'b1100},
    {1'b0, 80'h8000_8000000000000000, 4'b1110},
    {1'b1, 80'h3FFF_8000000000000000, 4'b1001},
    {1'b1, 80'hFFFF_C000000000000000, 4'b1011},
    {1'b0, 80'h7FFE_FFFFFFFFFFFFFFFF, 4'b0100}
  };

  function automatic string tagFor(logic emp, logic [3:0] cc);
    if (emp) return "R3";
    case ({cc[3], cc[2], cc[0]})
      3'b100:  return "R4";
      3'b001:  return "R5";
      3'b000:  return "R6";
      3'b011:  return "R7";
      3'b110:  return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Drive a strobe at negedge; result is sampled at the following negedge
  task automatic strobeOnce(logic emp, logic [79:0] v);
    inValid = 1'b1; inEmpty = emp; inValue = v;
    @(negedge clk);
    inValid = 1'b0; inEmpty = 1'b0; inValue = '0;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    logic [3:0] held;
    // R1: reset state, with a strobe held during reset
    inValid = 1'b1; inValue = 80'hFFFF_C000000000000000;
    repeat (3) @(negedge clk);
    check("R1 cc in reset", outCc, 4'b0000);
    check("R1 done in reset", {3'b0, outDone}, 4'b0000);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 cc after reset", outCc, 4'b0000);
    check("R1 done after reset", {3'b0, outDone}, 4'b0000);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      strobeOnce(VEC[i][84], VEC[i][83:4]);
      check(tagFor(VEC[i][84], VEC[i][3:0]), outCc, VEC[i][3:0]);
      check("R10 sign in C1", {3'b0, outCc[1]}, {3'b0, VEC[i][83]});
      check("R2 done pulse", {3'b0, outDone}, 4'b0001);
    end

    // R11: hold while idle, inputs toggling; R2 done low
    held = outCc;
    for (int k = 0; k < 3; k++) begin
      inEmpty = k[0];
      inValue = 80'h8000_0000000000000000 ^ {76'd0, k[3:0]};
      @(negedge clk);
      check("R11 hold when idle", outCc, held);
      check("R2 done low when idle", {3'b0, outDone}, 4'b0000);
    end
    inEmpty = 1'b0; inValue = '0;

    // Back-to-back strobes: done stays high, each code one cycle later
    inValid = 1'b1; inValue = 80'h7FFF_8000000000000000;
    @(negedge clk);
    check("R7 back-to-back first", outCc, 4'b0101);
    check("R2 done first", {3'b0, outDone}, 4'b0001);
    inEmpty = 1'b1; inValue = 80'h8000_0000000000000000;
    @(negedge clk);
    check("R3 back-to-back empty", outCc, 4'b1011);
    check("R2 done second", {3'b0, outDone}, 4'b0001);
    inValid = 1'b0; inEmpty = 1'b0;
    @(negedge clk);
    check("R2 done drops", {3'b0, outDone}, 4'b0000);
    check("R11 hold after burst", outCc, 4'b1011);

    // Unnormal with max fraction but integer bit clear
    strobeOnce(1'b0, 80'h4000_7FFFFFFFFFFFFFFF);
    check("R6 unnormal", outCc, 4'b0000);
    // NaN with only the top fraction bit set, negative
    strobeOnce(1'b0, 80'hFFFF_C000000000000000);
    check("R5 negative quiet NaN", outCc, 4'b0011);

    // Reset again mid-run clears outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R1 cc after re-reset", outCc, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    report();
  end

endmodule